// File: doc/BRIEF.md
# Register-Programmed Serial Peripheral Master

This block is a single-target SPI master driven from a host through a small 32-bit register window with plain write and read strobes. Software picks the word width and serial clock rate in a setup register, drives the one chip select through a control register, and starts a word by writing the outgoing data. Each word is full duplex: one bit leaves on MOSI per serial clock period while one bit is captured from MISO.

When the word has finished, a completion flag in a status register reads nonzero. Software then fetches the captured word from the receive register and clears the flag by writing zero to it. Only the clock-idles-low, sample-on-rise, change-on-fall mode is provided.

Top module: `spi_host_ctrl`

## Requirements
- R1: The byte offsets decode as: 0x00 control, 0x04 setup, 0x08 transmit, 0x0C receive, 0x10 completion status. The setup register reads back the six bits written to it and is 0 after reset.
- R2: Control bit 0 set drives `spi_cs_n` low and clear drives it high. After reset it is high.
- R3: Setup bit 5 set selects 16-bit words, and clear selects 8-bit words. In 8-bit mode the low byte of the transmit write is sent.
- R4: Setup bits [4:0] = P with bit 4 set and P >= 0x12 give a serial clock period of N = 2*(P-0x10) system clocks, so 0x12 gives 4 and 0x1F gives 30. Low and high phases are each N/2 clocks.
- R5: A prescale value with bit 4 clear or below 0x12 gives the minimum period of 4 clocks.
- R6: A write to the transmit register while idle starts a word. The first bit appears on MOSI in the cycle after the write edge. The word lasts exactly N*W clocks, where W is the word width.
- R7: The completion status reads 1 from the end of the word until a write of 0x00000000 to it. A write of any nonzero value leaves it unchanged. Completion wins over a clear in the same cycle.
- R8: After completion, the receive register returns the bits captured from MISO in arrival order, zero-extended: the low byte in 8-bit mode and the low half in 16-bit mode.
- R9: `spi_sck` is low when idle. MISO is captured when the clock rises, and MOSI changes only when the clock falls or a word starts.
- R10: Data leaves most significant bit first.
- R11: A transmit write during a word is ignored. Control bit 1 reads 1 while a word is in progress.
- R12: Setup changes made during a word apply only from the next word.
- R13: Read data appears one clock after the read strobe. Reads of the transmit register and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
A wrong phase timer or latched divide ratio shows on `spi_sck` within one half period, because each edge is predicted to the exact cycle. A bad transmit shift pointer shows on MOSI at the next falling clock. A corrupted bit counter either stretches or cuts the word, so the busy bit, the idle clock level and the status flag diverge within one clock of the expected end. A bad capture register appears only when the receive word is read back after completion, so each transfer ends with that read.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  localparam int PRESC_W = 5;
  localparam int HALF_W  = 4;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_SETUP = 8'h04;
  localparam logic [7:0] OFS_TX    = 8'h08;
  localparam logic [7:0] OFS_RX    = 8'h0C;
  localparam logic [7:0] OFS_DONE  = 8'h10;

  typedef struct packed {
    logic              wide;
    logic [HALF_W-1:0] half;
  } xfer_cfg_t;

  // half of the serial period, in system clocks, from the prescale code
  function automatic logic [HALF_W-1:0] half_of(input logic [PRESC_W-1:0] presc);
    logic [PRESC_W-1:0] diff;
    diff = presc - PRESC_W'(16);
    if (!presc[PRESC_W-1] || presc < PRESC_W'(18))
      return HALF_W'(2);
    return diff[HALF_W-1:0];
  endfunction

endpackage

// File: rtl/spi_host_engine.sv
module spi_host_engine
  import spi_host_pkg::*;
#(
  parameter int WORD_MAX = 16,
  parameter int NARROW   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  xfer_cfg_t           cfg,
  input  logic [WORD_MAX-1:0] tx_word,
  input  logic                miso,
  output logic                busy,
  output logic                sck,
  output logic                mosi,
  output logic                done,
  output logic [WORD_MAX-1:0] rx_word
);

  localparam int CNT_W = $clog2(WORD_MAX + 1);

  logic                busy_q, sck_q;
  logic [HALF_W-1:0]   tmr_q, half_q;
  logic [CNT_W-1:0]    bits_q;
  logic [WORD_MAX-1:0] txsh_q, rxsh_q;

  assign busy    = busy_q;
  assign sck     = sck_q;
  assign mosi    = txsh_q[WORD_MAX-1];
  assign rx_word = rxsh_q;
  assign done    = busy_q && sck_q && (tmr_q == '0) && (bits_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      tmr_q  <= '0;
      half_q <= HALF_W'(2);
      bits_q <= '0;
      txsh_q <= '0;
      rxsh_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        sck_q  <= 1'b0;
        half_q <= cfg.half;
        tmr_q  <= cfg.half - HALF_W'(1);
        bits_q <= cfg.wide ? CNT_W'(WORD_MAX) : CNT_W'(NARROW);
        txsh_q <= cfg.wide ? tx_word
                           : {tx_word[NARROW-1:0], {(WORD_MAX-NARROW){1'b0}}};
        rxsh_q <= '0;
      end
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - HALF_W'(1);
    end else begin
      tmr_q <= half_q - HALF_W'(1);
      if (!sck_q) begin
        sck_q  <= 1'b1;
        rxsh_q <= {rxsh_q[WORD_MAX-2:0], miso};
      end else begin
        sck_q  <= 1'b0;
        txsh_q <= {txsh_q[WORD_MAX-2:0], 1'b0};
        bits_q <= bits_q - CNT_W'(1);
        if (bits_q == CNT_W'(1))
          busy_q <= 1'b0;
      end
    end
  end

  assert_sck_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !sck_q);

  assert_mosi_hold_R9: assert property (@(posedge clk) disable iff (rst)
    sck_q |-> $stable(txsh_q[WORD_MAX-1]));

  assert_ratio_frozen_R12: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(half_q));

  assert_bits_range_R6: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (bits_q != '0 && bits_q <= CNT_W'(WORD_MAX)));

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int WORD_MAX = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic                rd,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                busy_i,
  input  logic                done_i,
  input  logic [WORD_MAX-1:0] rx_word,
  output logic [DATA_W-1:0]   rdata,
  output logic                cs_n,
  output logic                start,
  output xfer_cfg_t           cfg,
  output logic [WORD_MAX-1:0] tx_word
);

  localparam int SETUP_W = PRESC_W + 1;

  logic [7:0]         a8;
  logic               cs_q, done_q;
  logic [SETUP_W-1:0] setup_q;
  logic [DATA_W-1:0]  rdata_q;

  assign a8      = 8'(addr);
  assign start   = wr && (a8 == OFS_TX) && !busy_i;
  assign tx_word = wdata[WORD_MAX-1:0];
  assign cfg     = '{wide: setup_q[PRESC_W], half: half_of(setup_q[PRESC_W-1:0])};
  assign cs_n    = !cs_q;
  assign rdata   = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= 1'b0;
      setup_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (wr && a8 == OFS_CTRL)  cs_q    <= wdata[0];
      if (wr && a8 == OFS_SETUP) setup_q <= wdata[SETUP_W-1:0];
      if (done_i)
        done_q <= 1'b1;
      else if (wr && a8 == OFS_DONE && wdata == '0)
        done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= '0;
      if (rd) begin
        case (a8)
          OFS_CTRL:  rdata_q <= DATA_W'({busy_i, cs_q});
          OFS_SETUP: rdata_q <= DATA_W'(setup_q);
          OFS_RX:    rdata_q <= DATA_W'(rx_word);
          OFS_DONE:  rdata_q <= DATA_W'(done_q);
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
    done_i |=> done_q);

  assert_cs_released_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !cs_q);

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int WORD_MAX = 16,
  parameter int NARROW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);

  logic                busy, done, start;
  xfer_cfg_t           cfg;
  logic [WORD_MAX-1:0] tx_word, rx_word;

  spi_host_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_MAX(WORD_MAX)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .busy_i(busy), .done_i(done), .rx_word(rx_word),
    .rdata(bus_rdata), .cs_n(spi_cs_n), .start(start), .cfg(cfg),
    .tx_word(tx_word)
  );

  spi_host_engine #(
    .WORD_MAX(WORD_MAX), .NARROW(NARROW)
  ) u_engine (
    .clk(clk), .rst(rst), .start(start), .cfg(cfg), .tx_word(tx_word),
    .miso(spi_miso), .busy(busy), .sck(spi_sck), .mosi(spi_mosi),
    .done(done), .rx_word(rx_word)
  );

endmodule

// File: tb/spi_host_ctrl_test.sv
`timescale 1ns/1ps
module spi_host_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;

  always #10 clk = ~clk;

  spi_host_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  int vectors = 0;
  int errs = 0;
  bit finished = 0;

  // behavioural reference
  bit          m_busy, m_cs, m_flag, m_rd_pend;
  logic [5:0]  m_setup;
  int          m_c, m_h = 2, m_w = 8;
  logic [15:0] m_word, m_rx, slave_word = '0;
  logic [31:0] m_rd_exp;
  string       m_rd_tag;

  function automatic int half_model(logic [4:0] p);
    if (!p[4] || p < 5'h12) return 2;
    return int'(p) - 16;
  endfunction

  function automatic logic [15:0] width_mask(int w);
    return (w == 16) ? 16'hFFFF : 16'h00FF;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_cs = 0; m_flag = 0; m_setup = '0; m_rx = '0;
      m_c = 0; m_rd_pend = 0; m_word = '0;
    end else begin
      if (bus_rd) begin
        m_rd_pend = 1;
        case (bus_addr)
          5'h00: begin m_rd_exp = {30'b0, m_busy, m_cs}; m_rd_tag = "R2 R11 control read"; end
          5'h04: begin m_rd_exp = {26'b0, m_setup};       m_rd_tag = "R1 setup read"; end
          5'h0C: begin m_rd_exp = {16'b0, m_rx};          m_rd_tag = "R8 receive read"; end
          5'h10: begin m_rd_exp = {31'b0, m_flag};        m_rd_tag = "R7 status read"; end
          default: begin m_rd_exp = '0;                   m_rd_tag = "R13 empty read"; end
        endcase
      end
      if (bus_wr) begin
        if (bus_addr == 5'h00) m_cs = bus_wdata[0];
        if (bus_addr == 5'h04) m_setup = bus_wdata[5:0];
        if (bus_addr == 5'h10 && bus_wdata == 32'h0) m_flag = 0;
      end
      if (m_busy) begin
        if (m_c == 2*m_h*m_w - 1) begin
          m_busy = 0; m_flag = 1; m_rx = slave_word & width_mask(m_w);
        end else m_c++;
      end else if (bus_wr && bus_addr == 5'h08) begin
        m_busy = 1; m_c = 0; m_rx = '0;
        m_h = half_model(m_setup[4:0]);
        m_w = m_setup[5] ? 16 : 8;
        m_word = bus_wdata[15:0] & width_mask(m_w);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R4 R5 R9 sck", {31'b0, spi_sck},
            {31'b0, m_busy && ((m_c % (2*m_h)) >= m_h)});
      check("R3 R6 R10 R12 mosi", {31'b0, spi_mosi},
            {31'b0, m_busy ? m_word[m_w-1 - m_c/(2*m_h)] : 1'b0});
      check("R2 cs_n", {31'b0, spi_cs_n}, {31'b0, !m_cs});
      if (m_rd_pend) begin
        check(m_rd_tag, bus_rdata, m_rd_exp);
        m_rd_pend = 0;
      end
      spi_miso = m_busy ? slave_word[m_w-1 - m_c/(2*m_h)] : 1'b0;
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [4:0] a);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic word(logic [5:0] setup, logic [31:0] tx, logic [15:0] sw);
    wr(5'h04, {26'b0, setup});
    slave_word = sw;
    wr(5'h08, tx);
    wait_idle();
    rd(5'h10);
    rd(5'h0C);
    wr(5'h10, 32'h0);
    rd(5'h10);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL R6 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 R2: reset values
    rd(5'h04);
    rd(5'h00);
    // R2: assert chip select
    wr(5'h00, 32'h1);
    rd(5'h00);
    // R5 R10: default ratio, 8-bit
    word(6'h00, 32'h0000_00A5, 16'h003C);
    // R3 R4 R8: 16-bit, ratio 10, upper write bits ignored
    word(6'h35, 32'hFFFF_1234, 16'hBEEF);
    // R4: slowest ratio 30, 8-bit, upper byte of tx dropped
    word(6'h1F, 32'h0000_5A96, 16'h00C1);
    // R5: out-of-range prescale codes
    word(6'h05, 32'h0000_0081, 16'h0042);
    word(6'h11, 32'h0000_00FF, 16'h0000);
    word(6'h30, 32'h0000_8001, 16'hFFFF);
    // R4: smallest legal code in range
    word(6'h12, 32'h0000_0066, 16'h0099);
    // R11: transmit write during a word is ignored, busy visible
    wr(5'h04, 32'h0000_0000);
    slave_word = 16'h007E;
    wr(5'h08, 32'h0000_0081);
    wr(5'h08, 32'h0000_0000);
    rd(5'h00);
    wait_idle();
    rd(5'h0C);
    // R12: setup change mid-word applies to next word only
    wr(5'h04, 32'h0000_0032);
    slave_word = 16'h5AA5;
    wr(5'h08, 32'h0000_C3A5);
    wr(5'h04, 32'h0000_001F);
    wait_idle();
    rd(5'h0C);
    rd(5'h04);
    slave_word = 16'h0018;
    wr(5'h08, 32'h0000_00E7);
    wait_idle();
    rd(5'h0C);
    // R7: nonzero write keeps the flag, zero clears it
    wr(5'h10, 32'h0000_0005);
    rd(5'h10);
    wr(5'h10, 32'h0000_0000);
    rd(5'h10);
    // R13: transmit and unmapped reads give zero
    rd(5'h08);
    rd(5'h14);
    // R2: release chip select
    wr(5'h00, 32'h0);
    rd(5'h00);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule